// File: doc/BRIEF.md
# Reloadable Countdown Timer

A single-channel countdown timer sitting on a simple 32-bit register bus shaped like APB, with zero wait states. The bus master loads a 64-bit start value as two word registers, then sets an enable bit. The counter takes that value and counts down by one on every clock cycle in which the tick-enable input is high. A tick that arrives while the count is already zero is the terminal tick. It raises a pending flag.

A mode bit selects what happens at the terminal tick. In periodic mode the counter takes the start value again on that same tick, so a start value of L gives one event every L+1 ticks. In single-event mode the counter stays at zero and produces no further events until the enable bit is cleared and then set again. A separate unmask bit gates the pending flag onto a level interrupt line. The pending flag is cleared by writing a one to it.

Top module: `reload_timer`

Word offsets are: start value low word 0x00, start value high word 0x04, current count low word 0x08, current count high word 0x0C, control 0x10, pending status 0x18.

## Requirements
- R1: After reset every register reads zero and `irqOut` is low.
- R2: The start value words at 0x00 and 0x04 read back what was written. Offsets outside the map, and addresses whose two low bits are not zero, read as zero and ignore writes.
- R3: A control write that changes bit 0 (enable) from 0 to 1 copies the 64-bit start value {0x04, 0x00} into the counter. Start value writes do not change the count until the next such rising edge. A control write while already enabled does not reload.
- R4: The count falls by exactly one per cycle with `tickIn` high while enabled. With `tickIn` low, or with enable clear, the count holds.
- R5: In periodic mode (control bit 1 = 0), a tick at count zero sets the pending flag and reloads the start value on that same tick. This gives one event every L+1 ticks for start value L.
- R6: In single-event mode (control bit 1 = 1), the first tick at count zero sets the pending flag. The count then stays at zero, and later ticks raise no new event until enable goes through 0 and back to 1.
- R7: Pending status is bit 0 at offset 0x18. Writing 1 to that bit clears it and writing 0 leaves it unchanged. A terminal tick in the same cycle as a clear leaves the flag set.
- R8: `irqOut` is high exactly when the pending flag is set and control bit 2 (unmask) is set.
- R9: The counter is a true 64-bit down counter. A borrow from the low word decrements the high word, as seen on the count readback words.
- R10: Control reads back bits 2:0 as written, and its upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rstN | input | 1 | Active-low synchronous reset |
| pSel | input | 1 | Bus select |
| pEnable | input | 1 | Bus access phase |
| pWrite | input | 1 | 1 = write, 0 = read |
| pAddr | input | ADDR_W (5) | Byte address |
| pWdata | input | WORD_W (32) | Write data |
| pRdata | output | WORD_W (32) | Read data, combinational from address |
| tickIn | input | 1 | Timer tick enable, one tick per high cycle |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit words, which gives a 64-bit count, and a 5-bit address. At this size every offset in the map can be reached, including the misaligned and unused ones, and the high count word can be read back directly. Small start values keep periodic and single-event sequences short enough to step through tick by tick. A start value of 0x1_00000002 brings the low-to-high-word borrow within three ticks.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  // Number of bus words that make up the start value and the count.
  localparam int LOAD_WORDS = 2;

  // Word indexes (byte offset / 4) of the register map.
  localparam int IDX_LOAD_LO = 0;
  localparam int IDX_LOAD_HI = 1;
  localparam int IDX_CNT_LO  = 2;
  localparam int IDX_CNT_HI  = 3;
  localparam int IDX_CTRL    = 4;
  localparam int IDX_STAT    = 6;

  // Control bit positions.
  localparam int CTRL_EN      = 0;
  localparam int CTRL_ONESHOT = 1;
  localparam int CTRL_UNMASK  = 2;
  localparam int CTRL_BITS    = 3;

  // Strobes from the control side to the counting datapath.
  typedef struct packed {
    logic [LOAD_WORDS-1:0] wrLoad; // write one start value word
    logic                  take;   // copy start value into counter
    logic                  dec;    // count down by one
  } cnt_strobe_t;

endpackage

// File: rtl/reload_timer_count.sv
module reload_timer_count
  import reload_timer_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = LOAD_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cnt_strobe_t       strobe,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  count,
  output logic              countZero
);

  logic [WORD_W-1:0] loadReg [LOAD_WORDS];

  // One register per start value word.
  for (genvar w = 0; w < LOAD_WORDS; w++) begin : g_load
    always_ff @(posedge clk) begin
      if (!rstN) begin
        loadReg[w] <= '0;
      end else if (strobe.wrLoad[w]) begin
        loadReg[w] <= wdata;
      end
    end
    assign loadVal[w*WORD_W +: WORD_W] = loadReg[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.take) begin
      count <= loadVal;
    end else if (strobe.dec) begin
      count <= count - CNT_W'(1);
    end
  end

  assign countZero = (count == '0);

  // R3: a take strobe lands the start value in the counter.
  p_take_loads_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> count == $past(loadVal));

  // R4: a decrement strobe lowers the count by exactly one.
  p_dec_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.take) |=> count == $past(count) - CNT_W'(1));

  // R4: without a strobe the count holds.
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.dec && !strobe.take) |=> $stable(count));

  // R6: the counter never decrements past zero.
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dec && countZero));

endmodule

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5,
  localparam int CNT_W = LOAD_WORDS * WORD_W,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busEnable,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [CTRL_BITS-1:0] ctrlWdata,
  output logic [WORD_W-1:0]    busRdata,
  input  logic                 tickIn,
  input  logic [CNT_W-1:0]     loadVal,
  input  logic [CNT_W-1:0]     count,
  input  logic                 countZero,
  output cnt_strobe_t          strobe,
  output logic                 irqOut
);

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             wrAcc;
  logic             wrCtrl;
  logic             wrStat;
  logic             ctrlEn;
  logic             ctrlOneShot;
  logic             ctrlUnmask;
  logic             statusPend;
  logic             fired;
  logic             startEvt;
  logic             step;
  logic             terminal;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrAcc   = busSel && busEnable && busWrite && aligned;
  assign wrCtrl  = wrAcc && (wordIdx == IDX_W'(IDX_CTRL));
  assign wrStat  = wrAcc && (wordIdx == IDX_W'(IDX_STAT));

  // Enable rising edge caused by a control write.
  assign startEvt = wrCtrl && ctrlWdata[CTRL_EN] && !ctrlEn;
  // A tick that the counter acts on.
  assign step     = ctrlEn && tickIn && !fired;
  assign terminal = step && countZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn      <= 1'b0;
      ctrlOneShot <= 1'b0;
      ctrlUnmask  <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEn      <= ctrlWdata[CTRL_EN];
      ctrlOneShot <= ctrlWdata[CTRL_ONESHOT];
      ctrlUnmask  <= ctrlWdata[CTRL_UNMASK];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fired <= 1'b0;
    end else if (startEvt) begin
      fired <= 1'b0;
    end else if (terminal && ctrlOneShot) begin
      fired <= 1'b1;
    end
  end

  // Set has priority over the write-one clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusPend <= 1'b0;
    end else if (terminal) begin
      statusPend <= 1'b1;
    end else if (wrStat && ctrlWdata[0]) begin
      statusPend <= 1'b0;
    end
  end

  for (genvar w = 0; w < LOAD_WORDS; w++) begin : g_wr
    assign strobe.wrLoad[w] = wrAcc && (wordIdx == IDX_W'(IDX_LOAD_LO + w));
  end
  assign strobe.take = startEvt || (terminal && !ctrlOneShot);
  assign strobe.dec  = step && !countZero;

  assign irqOut = statusPend && ctrlUnmask;

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(IDX_LOAD_LO): busRdata = loadVal[0 +: WORD_W];
        IDX_W'(IDX_LOAD_HI): busRdata = loadVal[WORD_W +: WORD_W];
        IDX_W'(IDX_CNT_LO):  busRdata = count[0 +: WORD_W];
        IDX_W'(IDX_CNT_HI):  busRdata = count[WORD_W +: WORD_W];
        IDX_W'(IDX_CTRL):    busRdata = {{(WORD_W-CTRL_BITS){1'b0}},
                                         ctrlUnmask, ctrlOneShot, ctrlEn};
        IDX_W'(IDX_STAT):    busRdata = {{(WORD_W-1){1'b0}}, statusPend};
        default:             busRdata = '0;
      endcase
    end
  end

  // R7: a terminal tick always leaves the flag pending.
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    terminal |=> statusPend);

  // R7: a clear without a competing event empties the flag.
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && ctrlWdata[0] && !terminal) |=> !statusPend);

  // R6: once a single event has fired, only a new start reloads.
  p_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fired && !startEvt) |-> !strobe.take && !strobe.dec);

  // R3: a start leaves the timer enabled and armed.
  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |=> ctrlEn && !fired);

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [WORD_W-1:0] pWdata,
  output logic [WORD_W-1:0] pRdata,
  input  logic              tickIn,
  output logic              irqOut
);

  localparam int CNT_W = LOAD_WORDS * WORD_W;

  cnt_strobe_t      strobe;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] count;
  logic             countZero;

  reload_timer_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (pSel),
    .busEnable (pEnable),
    .busWrite  (pWrite),
    .busAddr   (pAddr),
    .ctrlWdata (pWdata[CTRL_BITS-1:0]),
    .busRdata  (pRdata),
    .tickIn    (tickIn),
    .loadVal   (loadVal),
    .count     (count),
    .countZero (countZero),
    .strobe    (strobe),
    .irqOut    (irqOut)
  );

  reload_timer_count #(.WORD_W(WORD_W)) i_count (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (pWdata),
    .loadVal   (loadVal),
    .count     (count),
    .countZero (countZero)
  );

endmodule

// File: tb/test_reload_timer.sv
module test_reload_timer;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pSel = 1'b0;
  logic              pEnable = 1'b0;
  logic              pWrite = 1'b0;
  logic [ADDR_W-1:0] pAddr = '0;
  logic [WORD_W-1:0] pWdata = '0;
  logic [WORD_W-1:0] pRdata;
  logic              tickIn = 1'b0;
  logic              irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [WORD_W-1:0] exp;
    string             tag;
  } item_t;

  item_t expQ[$];

  always #2.5 clk = ~clk;

  reload_timer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_reload_timer (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata), .tickIn(tickIn),
    .irqOut(irqOut)
  );

  // Monitor: compares read data during each read access phase.
  always @(negedge clk) begin
    if (pSel && pEnable && !pWrite) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL unexpected read: actual=%h expected=none", pRdata);
      end else begin
        item_t it;
        it = expQ.pop_front();
        if (pRdata !== it.exp) begin
          bad++;
          $display("FAIL %s addr=%h: actual=%h expected=%h",
                   it.tag, pAddr, pRdata, it.exp);
        end
      end
    end
  end

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    @(posedge clk); #1;
    pSel = 1'b1; pWrite = 1'b1; pAddr = a; pWdata = d; pEnable = 1'b0;
    @(posedge clk); #1;
    pEnable = 1'b1;
    @(posedge clk); #1;
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
  endtask

  // Driver: pushes the expected value, then performs the read.
  task automatic busRd(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] e,
                       input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
    pSel = 1'b1; pWrite = 1'b0; pAddr = a; pEnable = 1'b0;
    @(posedge clk); #1;
    pEnable = 1'b1;
    @(posedge clk); #1;
    pSel = 1'b0; pEnable = 1'b0;
  endtask

  task automatic doTicks(input int n);
    @(posedge clk); #1;
    tickIn = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    tickIn = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    total++;
    if (irqOut !== e) begin
      bad++;
      $display("FAIL %s irq: actual=%b expected=%b", tag, irqOut, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    busRd(5'h00, 32'h0, "R1 load lo");
    busRd(5'h04, 32'h0, "R1 load hi");
    busRd(5'h08, 32'h0, "R1 count lo");
    busRd(5'h0C, 32'h0, "R1 count hi");
    busRd(5'h10, 32'h0, "R1 ctrl");
    busRd(5'h18, 32'h0, "R1 status");
    chkIrq(1'b0, "R1");

    // R2: start value readback, unmapped and misaligned offsets
    busWr(5'h00, 32'h1122_3344);
    busWr(5'h04, 32'h5566_7788);
    busWr(5'h01, 32'hDEAD_BEEF);
    busRd(5'h00, 32'h1122_3344, "R2 load lo");
    busRd(5'h04, 32'h5566_7788, "R2 load hi");
    busRd(5'h14, 32'h0, "R2 unmapped 0x14");
    busRd(5'h1C, 32'h0, "R2 unmapped 0x1C");
    busRd(5'h01, 32'h0, "R2 misaligned");
    busRd(5'h08, 32'h0, "R3 count untouched by load write");

    // R10: control readback masks upper bits
    busWr(5'h10, 32'hFFFF_FFF8);
    busRd(5'h10, 32'h0, "R10 ctrl upper bits");

    // R5: periodic with start value 3
    busWr(5'h00, 32'd3);
    busWr(5'h04, 32'd0);
    busWr(5'h10, 32'h1);
    busRd(5'h10, 32'h1, "R10 ctrl readback");
    busRd(5'h08, 32'd3, "R3 loaded on enable");
    doTicks(3);
    busRd(5'h08, 32'd0, "R4 count after 3 ticks");
    busRd(5'h18, 32'd0, "R5 no event before terminal");
    doTicks(1);
    busRd(5'h18, 32'd1, "R5 event on 4th tick");
    busRd(5'h08, 32'd3, "R5 reload on terminal tick");
    chkIrq(1'b0, "R8 masked");
    busWr(5'h10, 32'h5);
    chkIrq(1'b1, "R8 unmasked");
    busRd(5'h08, 32'd3, "R3 no reload while enabled");
    busWr(5'h18, 32'h0);
    busRd(5'h18, 32'd1, "R7 write zero no effect");
    busWr(5'h18, 32'h1);
    busRd(5'h18, 32'd0, "R7 cleared");
    chkIrq(1'b0, "R8 after clear");
    doTicks(4);
    busRd(5'h18, 32'd1, "R5 second period");
    busRd(5'h08, 32'd3, "R5 second reload");
    repeat (5) @(posedge clk);
    busRd(5'h08, 32'd3, "R4 hold without tick");

    // R7: terminal tick coinciding with a clear keeps the flag
    doTicks(3);
    busRd(5'h08, 32'd0, "R4 at zero");
    @(posedge clk); #1;
    pSel = 1'b1; pWrite = 1'b1; pAddr = 5'h18; pWdata = 32'h1; pEnable = 1'b0;
    @(posedge clk); #1;
    pEnable = 1'b1; tickIn = 1'b1;
    @(posedge clk); #1;
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0; tickIn = 1'b0;
    busRd(5'h18, 32'd1, "R7 set wins over clear");
    busRd(5'h08, 32'd3, "R5 reload at collision");
    busWr(5'h18, 32'h1);

    // R3: start value written while enabled waits for next enable
    busWr(5'h00, 32'd100);
    busRd(5'h08, 32'd3, "R3 count kept while enabled");
    busWr(5'h10, 32'h0);
    doTicks(2);
    busRd(5'h08, 32'd3, "R4 hold while disabled");
    busWr(5'h10, 32'h1);
    busRd(5'h08, 32'd100, "R3 new value on re-enable");

    // R6: single event with start value 2
    busWr(5'h10, 32'h0);
    busWr(5'h00, 32'd2);
    busWr(5'h18, 32'h1);
    busWr(5'h10, 32'h7);
    busRd(5'h08, 32'd2, "R6 loaded");
    doTicks(2);
    busRd(5'h08, 32'd0, "R6 reached zero");
    busRd(5'h18, 32'd0, "R6 no event yet");
    chkIrq(1'b0, "R6 before event");
    doTicks(1);
    busRd(5'h18, 32'd1, "R6 event");
    chkIrq(1'b1, "R8 single event");
    busWr(5'h18, 32'h1);
    chkIrq(1'b0, "R8 cleared");
    doTicks(5);
    busRd(5'h18, 32'd0, "R6 no repeat");
    busRd(5'h08, 32'd0, "R6 holds zero");
    busWr(5'h10, 32'h0);
    busWr(5'h10, 32'h7);
    busRd(5'h08, 32'd2, "R6 rearmed");
    doTicks(3);
    busRd(5'h18, 32'd1, "R6 event after rearm");
    busWr(5'h10, 32'h0);
    busWr(5'h18, 32'h1);

    // R9: borrow across the word boundary
    busWr(5'h00, 32'd2);
    busWr(5'h04, 32'd1);
    busWr(5'h10, 32'h1);
    busRd(5'h08, 32'd2, "R9 lo loaded");
    busRd(5'h0C, 32'd1, "R9 hi loaded");
    doTicks(3);
    busRd(5'h08, 32'hFFFF_FFFF, "R9 lo after borrow");
    busRd(5'h0C, 32'd0, "R9 hi after borrow");
    busWr(5'h10, 32'h0);

    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule